// File: doc/BRIEF.md
# Mode-Switchable Byte Latch and Bus Driver

This block is a clocked model of a byte-wide port element. It has a bank of data latches and an output driver. A mode input chooses what the block is. With the mode input low, the block is a strobed input port: the strobe line loads the latches, and the driver is switched on only while the block is selected. With the mode input high, the block is a latching output port: the select term loads the latches, the strobe is ignored, and the driver stays on. If the select stays true while the mode input is high, the output follows the input and the block acts as a pass-through buffer.

The block has two select lines, one active low and one active high. It is selected only when both are asserted. The block does not drive real tri-state pins. Instead, the data output comes with an enable flag, and a surrounding bus multiplexer or pad ring turns that pair into a high-impedance driver. The latch-clock and driver-enable terms are sampled on the rising clock edge. The latches and the enable flag are registers that reset synchronously.

Top module: `mode_io_port`

## Requirements
- R1: While `rst` is high at a rising edge, `dout` becomes all zeros and `dout_en` becomes 0 on that edge.
- R2: The block counts as selected only when `sel_n` is 0 and `sel` is 1. In output mode, the other three combinations of the two select lines leave `dout` unchanged.
- R3: In input mode (`mode_out` = 0), `din` is loaded on every edge where `strobe` is 1 and appears on `dout` after that edge. On edges where `strobe` is 0, `dout` holds its value, whatever the select lines are.
- R4: In output mode (`mode_out` = 1), `strobe` has no effect. `din` is loaded on every edge where the block is selected.
- R5: After any edge that samples `mode_out` = 1, `dout_en` is 1.
- R6: After an edge that samples `mode_out` = 0, `dout_en` equals the select term sampled at that edge.
- R7: In output mode with the select held true, `dout` on each cycle equals `din` from the edge before (pass-through buffer).
- R8: In the input-port wiring, the active-low read pulse drives `sel_n` and the decoded address drives both `strobe` and `sel`. A read cycle then loads `din` and drives it with `dout_en` = 1. After the read ends, `dout_en` drops to 0 and the loaded byte is kept.
- R9: A change of `mode_out` on an edge where nothing loads the latches leaves `dout` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_out | input | 1 | 0 = input port, 1 = output port or pass-through buffer |
| sel_n | input | 1 | Active-low select |
| sel | input | 1 | Active-high select |
| strobe | input | 1 | Latch load strobe, used in input mode only |
| din | input | WIDTH | Data into the latches |
| dout | output | WIDTH | Latched data |
| dout_en | output | 1 | Driver enable (1 = drive the bus, 0 = high impedance) |

## Verification
Each result is due exactly one rising edge after the stimulus that causes it. The load decision and the driver enable are each registered once. The bench drives every input on the falling edge, lets a single rising edge pass, and samples on the next falling edge. So each check sees the state produced by exactly one sampled set of inputs. In the hold cases the new `din` differs from the stored byte, so any stray load shows up at the ports.

// File: rtl/iop_pkg.sv
package iop_pkg;
  typedef enum logic {
    MODE_IN  = 1'b0,
    MODE_OUT = 1'b1
  } port_mode_e;
endpackage

// File: rtl/iop_select.sv
module iop_select
  import iop_pkg::*;
(
  input  logic       sel_n,
  input  logic       sel,
  input  logic       strobe,
  input  port_mode_e mode,
  output logic       selected,
  output logic       load
);
  always_comb begin
    selected = ~sel_n & sel;
    unique case (mode)
      MODE_OUT: load = selected;
      default:  load = strobe;
    endcase
  end
endmodule

// File: rtl/iop_latch.sv
module iop_latch #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)       q[b] <= 1'b0;
      else if (load) q[b] <= din[b];
    end
  end

  // R3/R4: a load takes the input byte, and no load keeps the stored byte
  assert_load_takes_din_R3: assert property (@(posedge clk) disable iff (rst)
    load |=> q == $past(din));
  assert_hold_without_load_R3: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q));
endmodule

// File: rtl/iop_buffer_ctl.sv
module iop_buffer_ctl
  import iop_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  port_mode_e mode,
  input  logic       selected,
  output logic       oe
);
  always_ff @(posedge clk) begin
    if (rst)                   oe <= 1'b0;
    else if (mode == MODE_OUT) oe <= 1'b1;
    else                       oe <= selected;
  end

  assert_out_mode_drives_R5: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_OUT) |=> oe);
  assert_in_mode_idle_float_R6: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_IN && !selected) |=> !oe);
  assert_in_mode_sel_drive_R6: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_IN && selected) |=> oe);
endmodule

// File: rtl/mode_io_port.sv
module mode_io_port
  import iop_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_out,
  input  logic             sel_n,
  input  logic             sel,
  input  logic             strobe,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             dout_en
);
  port_mode_e mode;
  logic       selected;
  logic       load;

  assign mode = port_mode_e'(mode_out);

  iop_select u_select (
    .sel_n    (sel_n),
    .sel      (sel),
    .strobe   (strobe),
    .mode     (mode),
    .selected (selected),
    .load     (load)
  );

  iop_latch #(.WIDTH(WIDTH)) u_latch (
    .clk  (clk),
    .rst  (rst),
    .load (load),
    .din  (din),
    .q    (dout)
  );

  iop_buffer_ctl u_buf (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .selected (selected),
    .oe       (dout_en)
  );

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (dout == '0 && !dout_en));
  assert_strobe_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_out && !(!sel_n && sel)) |=> $stable(dout));
  assert_in_mode_no_strobe_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!mode_out && !strobe) |=> $stable(dout));
endmodule

// File: tb/mode_io_port_tb.sv
module mode_io_port_tb_top;
  localparam int W = 8;
  logic clk = 1'b0;
  logic rst;
  logic mode_out, sel_n, sel, strobe;
  logic [W-1:0] din, dout;
  logic dout_en;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mode_io_port #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .mode_out(mode_out), .sel_n(sel_n), .sel(sel),
    .strobe(strobe), .din(din), .dout(dout), .dout_en(dout_en)
  );

  task automatic check(string req, logic [W-1:0] exp_d, logic exp_en);
    n_checks++;
    if (dout !== exp_d || dout_en !== exp_en) begin
      n_fail++;
      $display("FAIL %s: dout=%02h en=%b expected dout=%02h en=%b",
               req, dout, dout_en, exp_d, exp_en);
    end
  endtask

  // drive on falling edge, one rising edge, sample on next falling edge
  task automatic cyc(logic m, logic sn, logic s, logic st, logic [W-1:0] d);
    mode_out = m; sel_n = sn; sel = s; strobe = st; din = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    cyc(1'b1, 1'b0, 1'b1, 1'b1, 8'hFF);
    check("R1 reset", 8'h00, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_input_mode;
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 8'hA5);
    check("R3 strobe load, R6 float", 8'hA5, 1'b0);
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 8'h3C);
    check("R3 hold without strobe", 8'hA5, 1'b0);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 8'h5A);
    check("R3 select no load, R6 drive", 8'hA5, 1'b1);
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 8'h5A);
    check("R6 deselect floats", 8'hA5, 1'b0);
  endtask

  task automatic t_mode_switch;
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 8'h77);
    check("R9 switch keeps byte, R5 drive", 8'hA5, 1'b1);
  endtask

  task automatic t_output_mode;
    cyc(1'b1, 1'b1, 1'b1, 1'b1, 8'h11);
    check("R2 sel_n high no load, R4 strobe ignored", 8'hA5, 1'b1);
    cyc(1'b1, 1'b0, 1'b0, 1'b1, 8'h22);
    check("R2 sel low no load", 8'hA5, 1'b1);
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 8'h33);
    check("R2 both off no load", 8'hA5, 1'b1);
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 8'h44);
    check("R4 selected load, R5 drive", 8'h44, 1'b1);
  endtask

  task automatic t_passthrough;
    logic [W-1:0] v;
    for (int i = 0; i < 4; i++) begin
      v = 8'h81 ^ W'(i * 8'h1D);
      cyc(1'b1, 1'b0, 1'b1, i[0], v);
      check("R7 follows input", v, 1'b1);
    end
  endtask

  task automatic t_input_wiring;
    // read_n -> sel_n, decoded address -> strobe and sel
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 8'hC3);
    check("R8 read drives byte", 8'hC3, 1'b1);
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
    check("R8 read ended floats and holds", 8'hC3, 1'b0);
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; mode_out = 1'b0; sel_n = 1'b1; sel = 1'b0; strobe = 1'b0; din = '0;
    @(negedge clk);
    t_reset();
    t_input_mode();
    t_mode_switch();
    t_output_mode();
    t_passthrough();
    t_input_wiring();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule